// File: doc/BRIEF.md
# Canned Test Message Sequencer

The block plays a fixed 64-character teleprinter test line after a single press of a start key. It does not emit line codes itself; it produces the address for a shared character code lookup table and also provides the message character for the current step from a small internal table. While a run is in progress, the block drives the table address bus in place of the keyboard path and raises a keyboard-inhibit flag, so the keyboard cannot produce codes until the message is complete.

A 6-bit step counter selects the character. The five low counter bits form address bits 0 to 4. Address bits 5 and 6 are forced low. The counter MSB appears on address bit 7, which is the line the keyboard path uses to choose the Morse or the teleprinter half of the table. A downstream buffer controller sends one advance strobe for each character it has consumed. A start is refused when the mode select indicates Morse or when another automatic string generator is busy. When the run ends, the counter parks at all-ones until the next accepted start.

Top module: `test_msg_seq`

## Requirements
- R1: After a synchronous active-high reset the block is idle: `active` is 0, `table_addr` equals `kbd_addr`, `kbd_inhibit` equals `other_busy`, and `msg_char` shows the parked slot 63 (space, 8'h20).
- R2: While `active` is 1, `table_addr` = {count[5], 2'b00, count[4:0]}, so address bits 6:5 are 0 and bit 7 selects the second 32-entry half for steps 32 to 63. While `active` is 0, `table_addr` equals `kbd_addr`.
- R3: A start is accepted on the rising edge of the synchronized `start_key` while `mode_morse` is 0. Holding the key yields exactly one start, and a press while `mode_morse` is 1 is ignored.
- R4: A press while `other_busy` is 1 is refused: the counter is not cleared and the block stays in its current state.
- R5: An accepted start sets the counter to 0 and raises `active`. Advance strobes are ignored until the synchronized key has been released.
- R6: In the running phase, each `advance` strobe adds one to the counter. A strobe at step 63 ends the run: `active` falls and the counter stays at 63.
- R7: `kbd_inhibit` is 1 whenever `active` or `other_busy` is 1, and 0 otherwise.
- R8: An `advance` strobe while the block is idle or waiting for key release has no effect on the counter.
- R9: `msg_char` gives the ASCII code of character `count` of "THE QUICK BROWN FOX JUMPS OVER THE LAZY DOG'S BACK 0123456789" (61 characters, step 0 = 'T'). Steps 61 to 63 give space, 8'h20.
- R10: An accepted start during a running message restarts it at step 0, in the wait-for-release phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_key | input | 1 | Raw start key level, high while pressed; asynchronous |
| mode_morse | input | 1 | 1 = Morse mode (start refused), 0 = teleprinter mode |
| other_busy | input | 1 | Another automatic string generator is active |
| advance | input | 1 | One-clock strobe from the buffer controller: character consumed |
| kbd_addr | input | 8 | Table address from the keyboard path |
| table_addr | output | 8 | Address to the shared code lookup table |
| msg_char | output | 8 | ASCII code of the current message step |
| kbd_inhibit | output | 1 | Holds off keyboard character production |
| active | output | 1 | This sequencer owns the table address bus |

## Verification
The assertions assume that `advance` is a single-cycle strobe in the clock domain and that `mode_morse` and `other_busy` stay steady around a key press. They also assume that `start_key` changes slowly compared with the clock, so the synchronizer sees every press as a clean level. The stimulus changes all inputs on the falling edge. It keeps each key press and release several cycles long, and it pulses `advance` for exactly one cycle with idle cycles between strobes.

// File: rtl/tms_pkg.sv
package tms_pkg;

    localparam int TMS_CNT_W  = 6;
    localparam int TMS_ADDR_W = 8;
    localparam int TMS_CHAR_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HOLD = 2'd1,
        PH_RUN  = 2'd2
    } tms_phase_e;

    localparam int TMS_MSG_LEN = 61;
    localparam logic [8*TMS_MSG_LEN-1:0] TMS_MSG_TEXT =
        "THE QUICK BROWN FOX JUMPS OVER THE LAZY DOG'S BACK 0123456789";
    localparam logic [TMS_CHAR_W-1:0] TMS_FILL = 8'h20;

    function automatic logic [TMS_CHAR_W-1:0] tms_char_at(input logic [TMS_CNT_W-1:0] idx);
        int pos;
        pos = int'(idx);
        if (pos < TMS_MSG_LEN)
            return TMS_MSG_TEXT[8*(TMS_MSG_LEN-1-pos) +: 8];
        return TMS_FILL;
    endfunction

endpackage

// File: rtl/tms_key_sync.sv
module tms_key_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic key_raw,
    output logic key_level,
    output logic key_rise
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t cur_q, nxt_d;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.chain = {cur_q.chain[STAGES-2:0], key_raw};
        nxt_d.prev  = cur_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt_d;
    end

    assign key_level = cur_q.chain[STAGES-1];
    assign key_rise  = cur_q.chain[STAGES-1] & ~cur_q.prev;

    // R3: a rising edge lasts a single cycle
    p_single_rise_r3: assert property (@(posedge clk) disable iff (rst)
        key_rise |=> !key_rise);
endmodule

// File: rtl/tms_seq_ctrl.sv
module tms_seq_ctrl
    import tms_pkg::*;
#(
    parameter int CNT_W = TMS_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_rise,
    input  logic             key_level,
    input  logic             mode_morse,
    input  logic             other_busy,
    input  logic             advance,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             kbd_inhibit
);
    localparam logic [CNT_W-1:0] CNT_LAST = '1;

    typedef struct packed {
        tms_phase_e       phase;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;
    logic  accept;
    logic  step;

    always_comb begin
        nxt_d  = cur_q;
        accept = start_rise && !mode_morse && !other_busy;
        step   = advance && kbd_inhibit && (cur_q.phase == PH_RUN);
        if (accept) begin
            nxt_d.phase = PH_HOLD;
            nxt_d.cnt   = '0;
        end else begin
            case (cur_q.phase)
                PH_HOLD: if (!key_level && kbd_inhibit) nxt_d.phase = PH_RUN;
                PH_RUN: begin
                    if (step) begin
                        if (cur_q.cnt == CNT_LAST) nxt_d.phase = PH_IDLE;
                        else                       nxt_d.cnt   = cur_q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.phase <= PH_IDLE;
            cur_q.cnt   <= CNT_LAST;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign count       = cur_q.cnt;
    assign running     = (cur_q.phase != PH_IDLE);
    assign kbd_inhibit = running | other_busy;

    // R5 / R10: accepted start clears the counter and waits for release
    p_clear_on_start_r5: assert property (@(posedge clk) disable iff (rst)
        (start_rise && !mode_morse && !other_busy) |=> (cur_q.cnt == '0 && cur_q.phase == PH_HOLD));
    // R4: a refused start leaves the idle state untouched
    p_busy_refuses_r4: assert property (@(posedge clk) disable iff (rst)
        (start_rise && other_busy && cur_q.phase == PH_IDLE) |=> (cur_q.phase == PH_IDLE));
    // R6: the idle counter is always parked at all-ones
    p_idle_park_r6: assert property (@(posedge clk) disable iff (rst)
        (cur_q.phase == PH_IDLE) |-> (cur_q.cnt == CNT_LAST));
    // R8: no advance is counted while waiting for release
    p_hold_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (cur_q.phase == PH_HOLD && !start_rise) |=> (cur_q.cnt == '0));
    // R6: without a strobe the running counter stays put
    p_run_needs_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        (cur_q.phase == PH_RUN && !advance && !start_rise) |=> $stable(cur_q.cnt));
    // R6: a strobe moves the counter by exactly one
    p_run_step_r6: assert property (@(posedge clk) disable iff (rst)
        (cur_q.phase == PH_RUN && advance && !start_rise && cur_q.cnt != CNT_LAST)
            |=> (cur_q.cnt == $past(cur_q.cnt) + 1'b1));
endmodule

// File: rtl/test_msg_seq.sv
module test_msg_seq
    import tms_pkg::*;
#(
    parameter int CNT_W       = TMS_CNT_W,
    parameter int ADDR_W      = TMS_ADDR_W,
    parameter int CHAR_W      = TMS_CHAR_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_key,
    input  logic              mode_morse,
    input  logic              other_busy,
    input  logic              advance,
    input  logic [ADDR_W-1:0] kbd_addr,
    output logic [ADDR_W-1:0] table_addr,
    output logic [CHAR_W-1:0] msg_char,
    output logic              kbd_inhibit,
    output logic              active
);
    localparam int LOW_W = CNT_W - 1;
    localparam int GAP_W = ADDR_W - CNT_W;

    logic             key_level;
    logic             key_rise;
    logic [CNT_W-1:0] count;
    logic [ADDR_W-1:0] seq_addr;

    tms_key_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .key_raw   (start_key),
        .key_level (key_level),
        .key_rise  (key_rise)
    );

    tms_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_rise  (key_rise),
        .key_level   (key_level),
        .mode_morse  (mode_morse),
        .other_busy  (other_busy),
        .advance     (advance),
        .count       (count),
        .running     (active),
        .kbd_inhibit (kbd_inhibit)
    );

    always_comb begin
        seq_addr = {count[CNT_W-1], {GAP_W{1'b0}}, count[LOW_W-1:0]};
        table_addr = active ? seq_addr : kbd_addr;
        msg_char   = tms_char_at(count);
    end

    // R2: control address lines are low during a run
    p_ctl_lines_low_r2: assert property (@(posedge clk) disable iff (rst)
        active |-> (table_addr[ADDR_W-2 -: GAP_W] == '0));
    // R7: the keyboard is held off throughout a run
    p_inhibit_when_active_r7: assert property (@(posedge clk) disable iff (rst)
        (active || other_busy) |-> kbd_inhibit);
    // R7: no inhibit without a cause
    p_inhibit_cause_r7: assert property (@(posedge clk) disable iff (rst)
        kbd_inhibit |-> (active || other_busy));
endmodule

// File: tb/tb_test_msg_seq.sv
module tb_test_msg_seq;
    logic       clk = 1'b0;
    logic       rst;
    logic       start_key, mode_morse, other_busy, advance;
    logic [7:0] kbd_addr;
    logic [7:0] table_addr, msg_char;
    logic       kbd_inhibit, active;

    int n_vec = 0;
    int n_err = 0;
    bit done  = 1'b0;

    localparam string MSG = "THE QUICK BROWN FOX JUMPS OVER THE LAZY DOG'S BACK 0123456789";

    always #2 clk = ~clk;

    test_msg_seq dut (
        .clk(clk), .rst(rst), .start_key(start_key), .mode_morse(mode_morse),
        .other_busy(other_busy), .advance(advance), .kbd_addr(kbd_addr),
        .table_addr(table_addr), .msg_char(msg_char),
        .kbd_inhibit(kbd_inhibit), .active(active)
    );

    function automatic logic [7:0] exp_char(input int i);
        if (i < MSG.len()) return 8'(MSG[i]);
        return 8'h20;
    endfunction

    function automatic logic [7:0] exp_addr(input int i);
        return {i[5], 2'b00, i[4:0]};
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_adv();
        advance = 1'b1;
        cyc(1);
        advance = 1'b0;
        cyc(1);
    endtask

    task automatic press();
        start_key = 1'b1;
        cyc(5);
    endtask

    task automatic release_key();
        start_key = 1'b0;
        cyc(5);
    endtask

    task automatic t_reset();
        rst = 1'b1; start_key = 1'b0; mode_morse = 1'b0; other_busy = 1'b0;
        advance = 1'b0; kbd_addr = 8'hA5;
        cyc(3);
        rst = 1'b0;
        cyc(2);
        chk({7'd0, active}, 8'd0, "R1 active after reset");
        chk(table_addr, 8'hA5, "R1 address from keyboard");
        chk({7'd0, kbd_inhibit}, 8'd0, "R1 inhibit after reset");
        chk(msg_char, 8'h20, "R1 parked slot char");
    endtask

    task automatic t_morse_ignored();
        t_reset();
        mode_morse = 1'b1;
        press();
        chk({7'd0, active}, 8'd0, "R3 morse mode refuses start");
        chk(table_addr, 8'hA5, "R3 keyboard keeps bus");
        release_key();
        mode_morse = 1'b0;
        cyc(2);
        chk({7'd0, active}, 8'd0, "R3 mode change alone no start");
    endtask

    task automatic t_busy_blocks();
        t_reset();
        other_busy = 1'b1;
        cyc(1);
        chk({7'd0, kbd_inhibit}, 8'd1, "R7 inhibit from other generator");
        press();
        chk({7'd0, active}, 8'd0, "R4 busy refuses start");
        chk(msg_char, 8'h20, "R4 counter not cleared");
        release_key();
        other_busy = 1'b0;
        cyc(1);
        chk({7'd0, kbd_inhibit}, 8'd0, "R7 inhibit drops");
    endtask

    task automatic t_full_run();
        t_reset();
        press();
        chk({7'd0, active}, 8'd1, "R5 start raises active");
        chk(table_addr, 8'h00, "R5 counter cleared");
        chk({7'd0, kbd_inhibit}, 8'd1, "R7 inhibit during run");
        pulse_adv();
        chk(table_addr, 8'h00, "R8 advance ignored while key held");
        cyc(6);
        chk({7'd0, active}, 8'd1, "R3 holding key gives one start");
        release_key();
        chk(table_addr, 8'h00, "R5 still step 0 after release");
        chk(msg_char, exp_char(0), "R9 first char");
        for (int i = 1; i < 64; i++) begin
            pulse_adv();
            chk(table_addr, exp_addr(i), $sformatf("R2 address step %0d", i));
            chk(msg_char, exp_char(i), $sformatf("R9 char step %0d", i));
            if (i == 20) begin
                cyc(3);
                chk(table_addr, exp_addr(20), "R6 no strobe no step");
            end
        end
        chk({7'd0, active}, 8'd1, "R6 still active at step 63");
        pulse_adv();
        chk({7'd0, active}, 8'd0, "R6 run ends after step 63");
        chk(table_addr, 8'hA5, "R2 bus returned to keyboard");
        chk(msg_char, 8'h20, "R6 counter parked at 63");
        chk({7'd0, kbd_inhibit}, 8'd0, "R7 inhibit released");
        pulse_adv();
        chk(msg_char, 8'h20, "R8 advance ignored when idle");
        chk({7'd0, active}, 8'd0, "R8 idle stays idle");
    endtask

    task automatic t_restart();
        t_reset();
        press();
        release_key();
        repeat (5) pulse_adv();
        chk(table_addr, exp_addr(5), "R6 five steps");
        press();
        chk(table_addr, 8'h00, "R10 restart clears counter");
        pulse_adv();
        chk(table_addr, 8'h00, "R10 restart waits for release");
        release_key();
        pulse_adv();
        chk(table_addr, exp_addr(1), "R10 counting after restart");
        other_busy = 1'b1;
        press();
        chk(table_addr, exp_addr(1), "R4 busy blocks restart");
        release_key();
        other_busy = 1'b0;
    endtask

    initial begin
        t_morse_ignored();
        t_busy_blocks();
        t_full_run();
        t_restart();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end
endmodule